// File: doc/BRIEF.md
# Branch Target Address Generator

This block computes where a taken branch or jump goes in a small microcontroller core with 16-bit physical addressing. The core presents the address of the instruction that follows the branch, a two-bit mode, and a 16-bit operand field, and then pulses `start`. There are two PC-relative forms, one with an 8-bit displacement and one with a 16-bit displacement. Either displacement is sign-extended and added to the 24-bit next-instruction address. The third form is memory-indirect. It uses an 8-bit pointer into the first 256 bytes of memory, and that location holds a 32-bit big-endian word.

In the indirect form the block reads the pointer word as two 16-bit accesses on a request/valid read port. The most significant byte of the word is a dummy, and the next byte is also lost when the 24-bit result is cut down to 16 bits. As a result, only the word at the pointer plus two reaches the target. Every result is reduced to 16 bits. The block reports it with a one-cycle `done` strobe and an `odd_err` flag that marks a target whose bit 0 is set.

Top module: `branch_target_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled, `done`, `odd_err` and `rd_req` are low and `target` is zero.
- R2: Mode encoding: `2'b00` is short relative and uses `disp[7:0]` as a signed byte, ignoring `disp[15:8]`. `2'b01` is long relative and uses all of `disp` as a signed word. Any mode with bit 1 set is indirect, with pointer `disp[7:0]`.
- R3: A short relative start accepted at a clock edge gives `done` high for the following cycle, with `target` equal to bits 15:0 of `next_pc` plus the sign-extended byte.
- R4: A long relative start behaves in the same way, adding the sign-extended 16-bit displacement.
- R5: The sum is formed at 24 bits, and its upper byte is discarded. Bits 23:16 of `next_pc` never change `target`.
- R6: An indirect start issues two reads, first at address `{8'h00, ptr}` and then at that address plus 2. `rd_req` stays high with a stable `rd_addr` until `rd_valid` is seen, and no address exceeds 0x01FF.
- R7: The indirect target equals the data of the second read. The first read's data has no effect. `done` rises in the cycle after the second `rd_valid`.
- R8: Whenever `done` is high, `odd_err` equals `target[0]`.
- R9: A `start` that arrives while `rd_req` is high is ignored. It produces no extra `done` and does not alter the fetch in progress.
- R10: An accepted start clears `odd_err` in the following cycle. For an indirect start, `done` is low in that cycle too.
- R11: A `start` that arrives in the same cycle `done` is high is accepted as a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation; inputs sampled with it |
| mode | input | 2 | Addressing form select (see R2) |
| next_pc | input | 24 | Address of the instruction after the branch |
| disp | input | 16 | Displacement, or pointer in bits 7:0 |
| rd_req | output | 1 | Read request to memory |
| rd_addr | output | 16 | Read byte address (even word access, big-endian) |
| rd_valid | input | 1 | Read data valid this cycle |
| rd_data | input | 16 | Read data, byte at `rd_addr` in bits 15:8 |
| done | output | 1 | Result strobe, one cycle per operation |
| target | output | 16 | Branch target physical address |
| odd_err | output | 1 | Target is odd; meaningful while `done` is high |

## Verification
Two events can meet in one cycle: the completion strobe of one operation and the start of the next. A second start can also overlap an indirect fetch that is still waiting on memory. The bench drives a new start at the exact negative edge where it sees `done` high, both after relative and after odd-target results. The scoreboard then has to receive both results, and `odd_err` must fall one cycle later. For the overlap case, a relative start is injected while `rd_req` is held high. Any additional `done`, or any change to the indirect result, is reported as a mismatch.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_HI   = 2'd1,
    FS_LO   = 2'd2
  } fetch_state_t;

  function automatic logic mode_is_indirect(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_is_long(input logic [1:0] m);
    return m[0];
  endfunction
endpackage

// File: rtl/bt_rel_adder.sv
module bt_rel_adder #(
  parameter int PC_W   = 24,
  parameter int DISP_W = 16,
  parameter int SHORT_W = 8
) (
  input  logic [PC_W-1:0]   next_pc,
  input  logic [DISP_W-1:0] disp,
  input  logic              long_sel,
  output logic [PC_W-1:0]   sum
);
  localparam int SHORT_PAD = PC_W - SHORT_W;
  localparam int LONG_PAD  = PC_W - DISP_W;

  logic [PC_W-1:0] ext_short;
  logic [PC_W-1:0] ext_long;

  generate
    if (LONG_PAD > 0) begin : g_pad_long
      assign ext_long = {{LONG_PAD{disp[DISP_W-1]}}, disp};
    end else begin : g_trim_long
      assign ext_long = disp[PC_W-1:0];
    end
  endgenerate

  assign ext_short = {{SHORT_PAD{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};

  always_comb begin
    sum = next_pc + (long_sel ? ext_long : ext_short);
  end
endmodule

// File: rtl/bt_ind_fetch.sv
module bt_ind_fetch
  import bt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int PTR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [PTR_W-1:0]  ptr,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              finish,
  output logic [DATA_W-1:0] low_word
);
  localparam int STEP = DATA_W / 8;

  fetch_state_t st_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= FS_IDLE;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        FS_IDLE: begin
          if (launch) begin
            st_q   <= FS_HI;
            addr_q <= {{(ADDR_W-PTR_W){1'b0}}, ptr};
          end
        end
        FS_HI: begin
          // Upper word carries only the dummy byte and bits that the
          // 16-bit truncation removes, so it is not stored.
          if (rd_valid) begin
            st_q   <= FS_LO;
            addr_q <= addr_q + ADDR_W'(STEP);
          end
        end
        FS_LO: begin
          if (rd_valid) st_q <= FS_IDLE;
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  assign rd_req   = (st_q != FS_IDLE);
  assign busy     = rd_req;
  assign rd_addr  = addr_q;
  assign finish   = (st_q == FS_LO) && rd_valid;
  assign low_word = rd_data;
endmodule

// File: rtl/bt_out_stage.sv
module bt_out_stage #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic [ADDR_W-1:0] value,
  output logic              done,
  output logic [ADDR_W-1:0] target,
  output logic              odd_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      target  <= '0;
      odd_err <= 1'b0;
    end else if (load) begin
      done    <= 1'b1;
      target  <= value;
      odd_err <= value[0];
    end else begin
      done <= 1'b0;
      if (clear) odd_err <= 1'b0;
    end
  end
endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen
  import bt_pkg::*;
#(
  parameter int PC_W   = 24,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int DISP_W = 16,
  parameter int PTR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [PC_W-1:0]   next_pc,
  input  logic [DISP_W-1:0] disp,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic [ADDR_W-1:0] target,
  output logic              odd_err
);
  logic              busy;
  logic              accept;
  logic              rel_load;
  logic              ind_launch;
  logic              ind_finish;
  logic [PC_W-1:0]   rel_sum;
  logic [DATA_W-1:0] ind_word;
  logic              load;
  logic [ADDR_W-1:0] load_val;

  assign accept     = start && !busy;
  assign ind_launch = accept && mode_is_indirect(mode);
  assign rel_load   = accept && !mode_is_indirect(mode);

  bt_rel_adder #(.PC_W(PC_W), .DISP_W(DISP_W), .SHORT_W(8)) u_rel (
    .next_pc (next_pc),
    .disp    (disp),
    .long_sel(mode_is_long(mode)),
    .sum     (rel_sum)
  );

  bt_ind_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_fetch (
    .clk     (clk),
    .rst     (rst),
    .launch  (ind_launch),
    .ptr     (disp[PTR_W-1:0]),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .rd_valid(rd_valid),
    .rd_data (rd_data),
    .busy    (busy),
    .finish  (ind_finish),
    .low_word(ind_word)
  );

  assign load     = rel_load || ind_finish;
  assign load_val = ind_finish ? ind_word[ADDR_W-1:0] : rel_sum[ADDR_W-1:0];

  bt_out_stage #(.ADDR_W(ADDR_W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .clear  (accept),
    .load   (load),
    .value  (load_val),
    .done   (done),
    .target (target),
    .odd_err(odd_err)
  );
endmodule

// File: rtl/bt_checker.sv
module bt_checker #(
  parameter int PC_W   = 24,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [1:0]        mode,
  input logic [PC_W-1:0]   next_pc,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic              done,
  input logic [ADDR_W-1:0] target,
  input logic              odd_err,
  input logic [PC_W-1:0]   rel_sum
);
  logic [7:0] hi_delta;
  always_comb hi_delta = rel_sum[PC_W-1:PC_W-8] - next_pc[PC_W-1:PC_W-8];

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!done && !odd_err && !rd_req && target == '0));

  a_r3_rel_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (start && !rd_req && !mode[1]) |=> (done && target == $past(rel_sum[ADDR_W-1:0])));

  a_r5_upper_carry: assert property (@(posedge clk) disable iff (rst)
    (start && !rd_req && !mode[1]) |-> (hi_delta == 8'h00 || hi_delta == 8'h01 || hi_delta == 8'hFF));

  a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  a_r6_low_page: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> ((rd_addr >> 9) == '0));

  a_r8_err_matches: assert property (@(posedge clk) disable iff (rst)
    done |-> (odd_err == target[0]));

  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (start && rd_req && !rd_valid) |=> !done);

  a_r10_clear_on_start: assert property (@(posedge clk) disable iff (rst)
    (start && !rd_req && mode[1]) |=> (!odd_err && !done && rd_req));
endmodule

bind branch_target_gen bt_checker #(.PC_W(PC_W), .ADDR_W(ADDR_W)) u_bt_checker (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .mode    (mode),
  .next_pc (next_pc),
  .rd_req  (rd_req),
  .rd_addr (rd_addr),
  .rd_valid(rd_valid),
  .done    (done),
  .target  (target),
  .odd_err (odd_err),
  .rel_sum (rel_sum)
);

// File: tb/branch_target_gen_test.sv
`timescale 1ns/1ps
module branch_target_gen_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        start = 0;
  logic [1:0]  mode = '0;
  logic [23:0] next_pc = '0;
  logic [15:0] disp = '0;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic        rd_valid = 0;
  logic [15:0] rd_data = '0;
  logic        done;
  logic [15:0] target;
  logic        odd_err;

  int total = 0;
  int bad = 0;
  int lat = 0;
  int rcnt = 0;
  logic [7:0] mem [0:519];
  logic [16:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] addr_q[$];

  always #2.5 clk = ~clk;

  branch_target_gen uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .next_pc(next_pc),
    .disp(disp), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done), .target(target), .odd_err(odd_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rel_exp(input logic [1:0] m, input logic [23:0] pc,
                                          input logic [15:0] d);
    logic [23:0] s;
    if (m[0]) s = pc + {{8{d[15]}}, d};
    else      s = pc + {{16{d[7]}}, d[7:0]};
    return s[15:0];
  endfunction

  task automatic issue(input logic [1:0] m, input logic [23:0] pc, input logic [15:0] d,
                       input string tag);
    logic [15:0] e;
    int p;
    if (m[1]) begin
      p = int'(d[7:0]);
      e = {mem[p+2], mem[p+3]};
      addr_q.push_back(16'(p));
      addr_q.push_back(16'(p + 2));
    end else begin
      e = rel_exp(m, pc, d);
    end
    exp_q.push_back({e[0], e});
    tag_q.push_back(tag);
    start = 1; mode = m; next_pc = pc; disp = d;
    @(negedge clk);
    start = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected done", 32'd1, 32'd0);
      end else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " target"}, {16'h0, target}, {16'h0, e[15:0]});
        check("R8 odd_err", {31'h0, odd_err}, {31'h0, e[16]});
      end
    end
  end

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      rd_valid = 0;
      if (rd_req) begin
        if (rcnt >= lat) begin
          int a;
          a = int'(rd_addr);
          rd_valid = 1;
          rd_data = {mem[a], mem[a+1]};
          rcnt = 0;
          if (addr_q.size() == 0) check("R6 unexpected read", 32'd1, 32'd0);
          else check("R6 read address", {16'h0, rd_addr}, {16'h0, addr_q.pop_front()});
        end else begin
          rcnt++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 520; i++) mem[i] = 8'((i * 73 + 29) & 255);
    repeat (3) @(negedge clk);
    check("R1 done", {31'h0, done}, 32'd0);
    check("R1 odd_err", {31'h0, odd_err}, 32'd0);
    check("R1 rd_req", {31'h0, rd_req}, 32'd0);
    check("R1 target", {16'h0, target}, 32'd0);
    rst = 0;
    @(negedge clk);

    // R3 short relative
    issue(2'b00, 24'h001000, 16'h007E, "R3");
    check("R3 done timing", {31'h0, done}, 32'd1);
    issue(2'b00, 24'h001000, 16'h0080, "R3");
    issue(2'b00, 24'h002001, 16'h0000, "R3");
    issue(2'b00, 24'h000002, 16'h00F0, "R3");
    drain();
    // R4 long relative
    issue(2'b01, 24'h001000, 16'h7FFE, "R4");
    check("R4 done timing", {31'h0, done}, 32'd1);
    issue(2'b01, 24'h009000, 16'h8000, "R4");
    issue(2'b01, 24'h000101, 16'hFFFF, "R4");
    drain();
    // R5 upper byte dropped
    issue(2'b01, 24'hABFFFE, 16'h0004, "R5");
    issue(2'b01, 24'hFFFFF0, 16'h0020, "R5");
    issue(2'b00, 24'h5A3000, 16'h0010, "R5");
    issue(2'b00, 24'h003000, 16'h0010, "R5");
    drain();
    // R2 mode field decode
    issue(2'b00, 24'h004000, 16'h1280, "R2 short ignores disp high");
    issue(2'b01, 24'h004000, 16'h1280, "R2 long");
    drain();
    lat = 1;
    issue(2'b11, 24'h777777, 16'hAB41, "R2 indirect code 3");
    drain();

    // R6/R7 indirect with timing
    for (int l = 0; l < 3; l++) begin
      int n;
      lat = l;
      issue(2'b10, 24'h000000, 16'h0010 + 16'(l * 6), "R7");
      n = 1;
      while (!done && n < 50) begin @(negedge clk); n++; end
      check("R7 done cycle", n, 2 * (l + 1) + 1);
      drain();
    end
    lat = 2;
    issue(2'b10, 24'h000000, 16'h00FF, "R6 top pointer");
    drain();
    // R7 dummy word has no effect
    lat = 0;
    mem[32'h30] = 8'hDE; mem[32'h31] = 8'hAD;
    issue(2'b10, 24'h0, 16'h0030, "R7 dummy A");
    drain();
    mem[32'h30] = 8'h01; mem[32'h31] = 8'h7C;
    issue(2'b10, 24'h0, 16'h0030, "R7 dummy B");
    drain();

    // R9 start during fetch ignored
    lat = 3;
    issue(2'b10, 24'h0, 16'h0044, "R9 fetch");
    @(negedge clk);
    start = 1; mode = 2'b00; next_pc = 24'h001234; disp = 16'h0003;
    @(negedge clk);
    start = 0;
    check("R9 no done after ignored start", {31'h0, done}, 32'd0);
    drain();
    check("R9 queue empty", exp_q.size(), 32'd0);

    // R10 / R11: start in done cycle after odd result
    lat = 1;
    issue(2'b00, 24'h002001, 16'h0002, "R11 odd");
    check("R11 done high at restart", {31'h0, done}, 32'd1);
    issue(2'b10, 24'h0, 16'h0050, "R11 indirect after odd");
    check("R10 odd_err cleared", {31'h0, odd_err}, 32'd0);
    check("R10 done low", {31'h0, done}, 32'd0);
    drain();
    // R11 back-to-back relative each cycle
    issue(2'b01, 24'h000100, 16'h0001, "R11 b2b");
    issue(2'b01, 24'h000100, 16'h0002, "R11 b2b");
    issue(2'b00, 24'h000100, 16'h00FF, "R11 b2b");
    drain();
    // start in done cycle of an indirect
    lat = 0;
    issue(2'b10, 24'h0, 16'h0060, "R11 ind");
    while (!done) @(negedge clk);
    issue(2'b00, 24'h000500, 16'h0006, "R11 after ind");
    check("R11 second done", {31'h0, done}, 32'd1);
    drain();
    check("R9 final queue empty", exp_q.size() + addr_q.size(), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule